// File: doc/BRIEF.md
# Dual-Mode 16-Point Fourier / Hartley Transform Engine

This block transforms a frame of sixteen real, signed 4-bit samples into sixteen result bins. A single mode input picks the kind of result: a complex Fourier spectrum (a real part and an imaginary part per bin), or a real Hartley spectrum. Both kinds come out of the same chain of four multiply-accumulate stages. Each stage computes its own coefficients from a folded quarter-wave sine table. The coefficient multiplexer in each stage changes per mode. No multiplier is duplicated.

Samples are written one at a time through a small load port while the engine is idle. A start strobe then launches the transform. The mode input is asynchronous: it passes through a synchronizer and is latched when the start strobe is accepted. It stays fixed until the transform ends. When the last bin is written, the engine emits a one-cycle done pulse. All 32 result words are then valid. They stay put until the next transform overwrites them. The work is issued as 64 tokens, one per pair of bin and group of four samples. Each token flows through the four stages, and a final adder merges the four partial sums of a bin.

Top module: `dual_xform16`

## Requirements
- R1: After reset, done is low and every real and imaginary result word reads zero.
- R2: While no transform is running, a cycle with load_en high stores load_data as the signed 4-bit two's-complement sample at index load_addr (0 to 15).
- R3: In Fourier mode (mode_sel value 0), real word k (bits k*18 to k*18+17 of res_re, signed) equals the sum over n of x[n]*C((k*n) mod 16). Here C(m) is 128*cos(2*pi*m/16) rounded to the nearest integer. No scaling is applied.
- R4: In Fourier mode, imaginary word k (same position in res_im) equals the sum over n of x[n]*(-S((k*n) mod 16)). Here S(m) is 128*sin(2*pi*m/16) rounded to the nearest integer.
- R5: In Hartley mode (mode_sel value 1), real word k equals the sum over n of x[n]*(C(m)+S(m)) with m = (k*n) mod 16. Every imaginary word reads zero.
- R6: done pulses high for exactly one cycle, 68 clock cycles after the edge that accepts start. The latency is the same in both modes, including the first run after a mode change. Results hold steady between done and the next start.
- R7: A start request while a transform is running is ignored. This includes the edge on which done rises. It causes no restart and no extra done pulse.
- R8: Load cycles while a transform is running are ignored. Neither the running transform nor any later one sees them.
- R9: mode_sel passes through a two-register synchronizer. The synchronized value is latched when start is accepted. A mode_sel change made in the same cycle as the start request is not used. A change during a run has no effect on that run.
- R10: Full-scale inputs (-8 and 7) give exact results with no overflow. For example, all samples at -8 in Fourier mode give real bin 0 equal to -16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Asynchronous mode select: 0 Fourier, 1 Hartley |
| load_en | input | 1 | Sample write strobe |
| load_addr | input | 4 | Sample index to write |
| load_data | input | 4 | Signed sample value |
| start | input | 1 | Start request |
| done | output | 1 | One-cycle completion pulse |
| res_re | output | 288 | Sixteen signed 18-bit real result words, bin k at bit k*18 |
| res_im | output | 288 | Sixteen signed 18-bit imaginary result words, bin k at bit k*18 |

## Verification
Two of the block's functions can meet in one cycle: the completion edge that raises done and clears the running state, and an incoming start request. The bench raises start so that it is sampled exactly on the completion edge. It then checks that the done pulse appears on that edge and that no second pulse follows within 80 cycles. In the same way, a mode_sel change is placed in the very cycle of a start request. That run is judged against the previous mode's expected spectrum, and the next settled start is judged against the new mode.

// File: rtl/dd_xform_pkg.sv
package dd_xform_pkg;

   localparam int COEF_W    = 10;
   localparam int COEF_FRAC = 7;

   typedef enum logic {
      MODE_FOURIER = 1'b0,
      MODE_HARTLEY = 1'b1
   } xform_mode_e;

   // sine of m*22.5 degrees scaled by 2**COEF_FRAC, folded from one quadrant
   function automatic logic signed [COEF_W-1:0] sin_q7(input logic [3:0] m);
      logic [2:0] h;
      logic [2:0] q;
      logic signed [COEF_W-1:0] mag;
      h = m[2:0];
      q = (h > 3'd4) ? (3'd0 - h) : h;
      case (q)
         3'd0:    mag = COEF_W'(0);
         3'd1:    mag = COEF_W'(49);
         3'd2:    mag = COEF_W'(91);
         3'd3:    mag = COEF_W'(118);
         default: mag = COEF_W'(128);
      endcase
      return m[3] ? -mag : mag;
   endfunction

endpackage

// File: rtl/dd_sample_bank.sv
module dd_sample_bank #(
   parameter int N    = 16,
   parameter int IN_W = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  busy,
   input  logic                  load_en,
   input  logic [IDX_W-1:0]      load_addr,
   input  logic [IN_W-1:0]       load_data,
   output logic [N*IN_W-1:0]     samples
);

   logic [N-1:0][IN_W-1:0] mem_q;

   for (genvar i = 0; i < N; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem_q[i] <= '0;
         else if (load_en && !busy && load_addr == IDX_W'(i))
            mem_q[i] <= load_data;
      end
   end

   assign samples = mem_q;

   // R8: sample store frozen while a transform runs
   a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem_q));

endmodule

// File: rtl/dd_coef_rom.sv
module dd_coef_rom
   import dd_xform_pkg::*;
#(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [IDX_W-1:0]         bin,
   input  logic [IDX_W-1:0]         term,
   output logic signed [COEF_W-1:0] cos_c,
   output logic signed [COEF_W-1:0] sin_c
);

   logic [IDX_W-1:0] angle;
   logic [IDX_W-1:0] angle_q;

   assign angle   = bin * term;
   assign angle_q = angle + IDX_W'(N / 4);
   assign sin_c   = sin_q7(angle);
   assign cos_c   = sin_q7(angle_q);

endmodule

// File: rtl/dd_mac_stage.sv
module dd_mac_stage
   import dd_xform_pkg::*;
#(
   parameter int STAGE = 0,
   parameter int N     = 16,
   parameter int TERMS = 4,
   parameter int IN_W  = 4,
   parameter int ACC_W = 18,
   localparam int IDX_W = $clog2(N),
   localparam int J_W   = $clog2(TERMS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hartley,
   input  logic [N*IN_W-1:0]       samples,
   input  logic                    in_vld,
   input  logic [IDX_W-1:0]        in_k,
   input  logic [J_W-1:0]          in_j,
   input  logic signed [ACC_W-1:0] in_re,
   input  logic signed [ACC_W-1:0] in_im,
   output logic                    out_vld,
   output logic [IDX_W-1:0]        out_k,
   output logic [J_W-1:0]          out_j,
   output logic signed [ACC_W-1:0] out_re,
   output logic signed [ACC_W-1:0] out_im
);

   localparam int BASE = STAGE * TERMS;

   logic [IDX_W-1:0]         n_idx;
   logic signed [IN_W-1:0]   x;
   logic signed [COEF_W-1:0] cos_c, sin_c, coef_re, coef_im;
   logic signed [ACC_W-1:0]  x_ext, cre_ext, cim_ext, prod_re, prod_im;

   assign n_idx = IDX_W'(BASE) + IDX_W'(in_j);
   assign x     = samples[n_idx*IN_W +: IN_W];

   dd_coef_rom #(.N(N)) rom_i (
      .bin   (in_k),
      .term  (n_idx),
      .cos_c (cos_c),
      .sin_c (sin_c)
   );

   // mode only steers the coefficients; both multipliers are shared
   always_comb begin
      if (hartley) begin
         coef_re = cos_c + sin_c;
         coef_im = '0;
      end else begin
         coef_re = cos_c;
         coef_im = -sin_c;
      end
   end

   assign x_ext   = {{(ACC_W-IN_W){x[IN_W-1]}}, x};
   assign cre_ext = {{(ACC_W-COEF_W){coef_re[COEF_W-1]}}, coef_re};
   assign cim_ext = {{(ACC_W-COEF_W){coef_im[COEF_W-1]}}, coef_im};
   assign prod_re = x_ext * cre_ext;
   assign prod_im = x_ext * cim_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_k   <= '0;
         out_j   <= '0;
         out_re  <= '0;
         out_im  <= '0;
      end else begin
         out_vld <= in_vld;
         out_k   <= in_k;
         out_j   <= in_j;
         out_re  <= in_re + prod_re;
         out_im  <= in_im + prod_im;
      end
   end

   // R5: the imaginary lane carries nothing in Hartley mode
   a_r5_hartley_im_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && hartley) |-> (out_im == '0));

endmodule

// File: rtl/dd_sequencer.sv
module dd_sequencer
   import dd_xform_pkg::*;
#(
   parameter int N           = 16,
   parameter int TERMS       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W = $clog2(N * TERMS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_async,
   input  logic             start,
   input  logic             fin,
   output logic             busy,
   output logic             issue,
   output logic [CNT_W-1:0] cnt,
   output logic             hartley
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(N * TERMS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   mode_synced;
   xform_mode_e            mode_q;
   logic                   busy_q, issue_q;
   logic [CNT_W-1:0]       cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], mode_async};
   end
   assign mode_synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         issue_q <= 1'b0;
         cnt_q   <= '0;
         mode_q  <= MODE_FOURIER;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         issue_q <= 1'b1;
         cnt_q   <= '0;
         mode_q  <= xform_mode_e'(mode_synced);
      end else begin
         if (issue_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == LAST) issue_q <= 1'b0;
         end
         if (fin) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign issue   = issue_q;
   assign cnt     = cnt_q;
   assign hartley = (mode_q == MODE_HARTLEY);

   // R9: latched mode never moves during a run
   a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(mode_q));

   // R7: issuing proceeds one token per cycle whatever start does
   a_r7_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_q && cnt_q != LAST) |=> (issue_q && cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/dual_xform16.sv
module dual_xform16
   import dd_xform_pkg::*;
#(
   parameter int N           = 16,
   parameter int IN_W        = 4,
   parameter int STAGES      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W = $clog2(N),
   localparam int TERMS = N / STAGES,
   localparam int J_W   = $clog2(TERMS),
   localparam int CNT_W = IDX_W + J_W,
   localparam int ACC_W = IN_W + COEF_W + IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_sel,
   input  logic                 load_en,
   input  logic [IDX_W-1:0]     load_addr,
   input  logic [IN_W-1:0]      load_data,
   input  logic                 start,
   output logic                 done,
   output logic [N*ACC_W-1:0]   res_re,
   output logic [N*ACC_W-1:0]   res_im
);

   if (N != 16) begin : g_bad_n
      $error("dual_xform16: coefficient folding assumes N == 16");
   end
   if (STAGES < 2 || STAGES >= N || (N % STAGES) != 0) begin : g_bad_stages
      $error("dual_xform16: STAGES must divide N and leave at least two terms");
   end
   if (TERMS != (1 << J_W)) begin : g_bad_terms
      $error("dual_xform16: terms per stage must be a power of two");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dual_xform16: synchronizer needs at least two registers");
   end
   if (IN_W < 2) begin : g_bad_in
      $error("dual_xform16: sample width too small");
   end

   logic                busy, issue, hartley, fin;
   logic [CNT_W-1:0]    cnt;
   logic [N*IN_W-1:0]   samples;

   logic [STAGES:0]                 st_vld;
   logic [STAGES:0][IDX_W-1:0]      st_k;
   logic [STAGES:0][J_W-1:0]        st_j;
   logic [STAGES:0][ACC_W-1:0]      st_re;
   logic [STAGES:0][ACC_W-1:0]      st_im;

   logic signed [ACC_W-1:0]         acc_re_q, acc_im_q, sum_re, sum_im;
   logic [N-1:0][ACC_W-1:0]         res_re_q, res_im_q;
   logic                            done_q;

   dd_sample_bank #(.N(N), .IN_W(IN_W)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data),
      .samples   (samples)
   );

   dd_sequencer #(.N(N), .TERMS(TERMS), .SYNC_STAGES(SYNC_STAGES)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_async (mode_sel),
      .start      (start),
      .fin        (fin),
      .busy       (busy),
      .issue      (issue),
      .cnt        (cnt),
      .hartley    (hartley)
   );

   assign st_vld[0] = issue;
   assign st_k[0]   = cnt[CNT_W-1:J_W];
   assign st_j[0]   = cnt[J_W-1:0];
   assign st_re[0]  = '0;
   assign st_im[0]  = '0;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      dd_mac_stage #(
         .STAGE (s),
         .N     (N),
         .TERMS (TERMS),
         .IN_W  (IN_W),
         .ACC_W (ACC_W)
      ) mac_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .hartley (hartley),
         .samples (samples),
         .in_vld  (st_vld[s]),
         .in_k    (st_k[s]),
         .in_j    (st_j[s]),
         .in_re   (st_re[s]),
         .in_im   (st_im[s]),
         .out_vld (st_vld[s+1]),
         .out_k   (st_k[s+1]),
         .out_j   (st_j[s+1]),
         .out_re  (st_re[s+1]),
         .out_im  (st_im[s+1])
      );
   end

   // merge the per-group partial sums of one bin
   assign sum_re = acc_re_q + $signed(st_re[STAGES]);
   assign sum_im = acc_im_q + $signed(st_im[STAGES]);
   assign fin    = st_vld[STAGES] && st_j[STAGES] == J_W'(TERMS - 1)
                   && st_k[STAGES] == IDX_W'(N - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_re_q <= '0;
         acc_im_q <= '0;
         res_re_q <= '0;
         res_im_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= fin;
         if (st_vld[STAGES]) begin
            if (st_j[STAGES] == '0) begin
               acc_re_q <= $signed(st_re[STAGES]);
               acc_im_q <= $signed(st_im[STAGES]);
            end else begin
               acc_re_q <= sum_re;
               acc_im_q <= sum_im;
            end
            if (st_j[STAGES] == J_W'(TERMS - 1)) begin
               res_re_q[st_k[STAGES]] <= sum_re;
               res_im_q[st_k[STAGES]] <= sum_im;
            end
         end
      end
   end

   assign done   = done_q;
   assign res_re = res_re_q;
   assign res_im = res_im_q;

   // R6: done is a single-cycle pulse
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R6: the engine is idle once done is shown
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy);

   // R7: no token enters the pipeline without a running transform
   a_r7_tokens_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld[STAGES] |-> busy);

endmodule

// File: tb/dual_xform16_tb_top.sv
module dual_xform16_tb_top;

   localparam int N     = 16;
   localparam int IN_W  = 4;
   localparam int ACC_W = 18;
   localparam int LAT   = 68;
   localparam real PI   = 3.14159265358979;

   logic clk = 1'b0;
   logic rst_n, mode_sel, load_en, start;
   logic [3:0] load_addr;
   logic [IN_W-1:0] load_data;
   logic done;
   logic [N*ACC_W-1:0] res_re, res_im;

   int checks = 0;
   int fails  = 0;
   int xs[N];

   always #5 clk = ~clk;

   dual_xform16 dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data),
      .start     (start),
      .done      (done),
      .res_re    (res_re),
      .res_im    (res_im)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rnd(real v);
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(-v + 0.5);
   endfunction

   function automatic int cq(int m);
      return rnd(128.0 * $cos(2.0 * PI * m / 16.0));
   endfunction

   function automatic int sq(int m);
      return rnd(128.0 * $sin(2.0 * PI * m / 16.0));
   endfunction

   function automatic int exp_re(int k, bit h);
      int s = 0;
      for (int n = 0; n < N; n++) begin
         int m = (k * n) % N;
         s += xs[n] * (cq(m) + (h ? sq(m) : 0));
      end
      return s;
   endfunction

   function automatic int exp_im(int k, bit h);
      int s = 0;
      if (h) return 0;
      for (int n = 0; n < N; n++) s -= xs[n] * sq((k * n) % N);
      return s;
   endfunction

   function automatic int got_re(int k);
      logic signed [ACC_W-1:0] v;
      v = res_re[k*ACC_W +: ACC_W];
      return int'(v);
   endfunction

   function automatic int got_im(int k);
      logic signed [ACC_W-1:0] v;
      v = res_im[k*ACC_W +: ACC_W];
      return int'(v);
   endfunction

   task automatic load_all();
      for (int n = 0; n < N; n++) begin
         @(negedge clk);
         load_en   = 1'b1;
         load_addr = 4'(n);
         load_data = IN_W'(xs[n]);
      end
      @(negedge clk);
      load_en = 1'b0;
   endtask

   // settle=1: mode_sel set well before start; settle=0: set with start
   task automatic launch(input bit m, input bit settle);
      @(negedge clk);
      if (settle) begin
         mode_sel = m;
         repeat (3) @(posedge clk);
         @(negedge clk);
      end else begin
         mode_sel = m;
      end
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input int n0, output int n);
      n = n0;
      forever begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (done || n > 200) break;
      end
   endtask

   task automatic check_results(input bit h, input string tag);
      for (int k = 0; k < N; k++) begin
         chk(tag, got_re(k), exp_re(k, h));
         chk(tag, got_im(k), exp_im(k, h));
      end
   endtask

   task automatic run_and_check(input bit h, input string tag);
      int n;
      launch(h, 1'b1);
      wait_done(0, n);
      chk({tag, " R6 latency"}, n, LAT);
      check_results(h, tag);
      @(negedge clk);
      chk("R6 done width", int'(done), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; mode_sel = 1'b0; load_en = 1'b0; start = 1'b0;
      load_addr = '0; load_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done", int'(done), 0);
      for (int k = 0; k < N; k++) begin
         chk("R1 re", got_re(k), 0);
         chk("R1 im", got_im(k), 0);
      end
   endtask

   task automatic t_impulse();
      for (int n = 0; n < N; n++) xs[n] = 0;
      xs[1] = 1;
      load_all();
      run_and_check(1'b0, "R2 R3 R4 impulse");
   endtask

   task automatic t_pattern();
      xs = '{3, -2, 7, -8, 0, 5, -1, 4, 2, -7, 6, 1, -3, -5, 0, 7};
      load_all();
      run_and_check(1'b0, "R3 R4 pattern");
      run_and_check(1'b1, "R5 pattern after switch");
      repeat (10) @(posedge clk);
      @(negedge clk);
      check_results(1'b1, "R6 hold");
      run_and_check(1'b0, "R3 back to fourier");
   endtask

   task automatic t_extremes();
      for (int n = 0; n < N; n++) xs[n] = (n % 2 == 0) ? 7 : -8;
      load_all();
      run_and_check(1'b1, "R10 alternating hartley");
      run_and_check(1'b0, "R10 alternating fourier");
      for (int n = 0; n < N; n++) xs[n] = -8;
      load_all();
      run_and_check(1'b0, "R10 all min");
      chk("R10 dc bin", got_re(0), -16384);
   endtask

   task automatic t_mode_sync();
      int n;
      xs = '{1, 2, 3, 4, -1, -2, -3, -4, 5, 0, -5, 6, 0, -6, 7, -8};
      load_all();
      run_and_check(1'b0, "R9 base fourier");
      launch(1'b1, 1'b0);
      wait_done(0, n);
      chk("R9 late change latency", n, LAT);
      check_results(1'b0, "R9 late change ignored");
      launch(1'b1, 1'b1);
      repeat (10) @(posedge clk);
      @(negedge clk);
      mode_sel = 1'b0;
      wait_done(10, n);
      chk("R9 mid-run latency", n, LAT);
      check_results(1'b1, "R9 mid-run change ignored");
   endtask

   task automatic t_start_busy();
      int n;
      bit extra;
      launch(1'b0, 1'b1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_done(21, n);
      chk("R7 mid-run start latency", n, LAT);
      check_results(1'b0, "R7 mid-run start");
      launch(1'b1, 1'b1);
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R7 done on collision edge", int'(done), 1);
      extra = 1'b0;
      repeat (80) begin
         @(posedge clk);
         @(negedge clk);
         if (done) extra = 1'b1;
      end
      chk("R7 no restart at done edge", int'(extra), 0);
      check_results(1'b1, "R7 collision results");
   endtask

   task automatic t_load_busy();
      int n;
      xs = '{-1, 4, -6, 2, 7, -3, 0, 1, -8, 5, 3, -2, 6, -7, 2, 0};
      load_all();
      launch(1'b0, 1'b1);
      repeat (5) @(posedge clk);
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         load_en   = 1'b1;
         load_addr = 4'(a * 3);
         load_data = 4'd5;
      end
      @(negedge clk);
      load_en = 1'b0;
      wait_done(10, n);
      chk("R8 done seen", int'(done), 1);
      check_results(1'b0, "R8 load during run");
      run_and_check(1'b1, "R8 later run");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_impulse();
      t_pattern();
      t_extremes();
      t_mode_sync();
      t_start_busy();
      t_load_busy();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule